// File: doc/BRIEF.md
# Iterative Salsa20 Core Engine

This block computes the Salsa20 core function on one 512-bit block: sixteen 32-bit words, word i in bits [32i+31:32i]. A start pulse captures the block and a round count. The engine then alternates a column round and a row round, one full round per clock cycle, with four quarterrounds running in parallel each cycle. When the rounds are done it adds the captured input to the final state word by word. It presents the sum on `dout` and raises `done` for one cycle.

Key and nonce placement, block-counter stepping and XOR with data belong to the surrounding logic. This engine only turns a prepared state into the core output. The round count is taken at run time. It is consumed two rounds at a time, so an odd count behaves as the next even count.

Top module: `salsa_core`

## Requirements
- R1: While `rst` (active-high, synchronous) is high and in the cycle after it drops, `busy`, `done` and `dout` are all zero. A reset during a run abandons that run.
- R2: A quarterround on words (a,b,c,d) applies four dependent steps in order, with all sums modulo 2^32: b ^= rotl(a+d,7), then c ^= rotl(b+a,9), then d ^= rotl(c+b,13), then a ^= rotl(d+c,18).
- R3: A column round applies R2 to the groups (0,4,8,12), (5,9,13,1), (10,14,2,6) and (15,3,7,11). The following row round applies it to (0,1,2,3), (5,6,7,4), (10,11,8,9) and (15,12,13,14). Each group is listed as (a,b,c,d). Every double round is a column round followed by a row round.
- R4: Each output word is the final state word plus the captured input word of the same index, modulo 2^32. An all-zero input gives an all-zero output.
- R5: Output word i sits in `dout` bits [32i+31:32i], the same position as input word i in `din`.
- R6: A start accepted while idle raises `busy` on the next cycle. `done` rises exactly E+1 clock edges after the accepting edge, where E is the round count rounded up to even. `busy` is low whenever `done` is high.
- R7: `done` is high for exactly one cycle per run.
- R8: A start pulse while `busy` is high is ignored. The running block's result and timing are unchanged.
- R9: A round count of 0 runs no rounds. `done` comes one edge after the accepting edge, and every output word is twice the input word modulo 2^32.
- R10: An odd round count gives the same result and timing as the next even count (7 behaves as 8).
- R11: `dout` holds its value in every cycle other than the one in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run. Acted on only while idle |
| nr | input | NR_W (8) | Number of rounds, captured with start |
| din | input | 512 | Input block, word 0 in the low 32 bits |
| dout | output | 512 | Core output, word 0 in the low 32 bits |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when `dout` is updated |

## Verification
The hardest case to reach from the ports is a second start arriving in the middle of a run. A design that accepted it would swap the captured block and the round count. The bench reaches this by driving start again, with inverted data and a count of 2, five cycles into a 20-round run. It then requires the original result at the original latency. A second hard case is a reset mid-run: the bench pulses reset while busy is high and checks that every output clears. Odd and zero round counts are driven directly, and the bench compares them with the rounded-up result and the doubled input.

// File: rtl/salsa_pkg.sv
package salsa_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 16;
    localparam int N_GRP   = 4;
    localparam int BLK_W   = WORD_W * N_WORDS;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [N_WORDS-1:0] state_t;
    // quad_t index: 0 = a, 1 = b, 2 = c, 3 = d
    typedef word_t [3:0] quad_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_COL  = 2'd1,
        PH_ROW  = 2'd2,
        PH_FEED = 2'd3
    } phase_e;

    function automatic word_t rotl(input word_t v, input int unsigned s);
        return (v << s) | (v >> (WORD_W - s));
    endfunction

    // Column group g walks down the column that starts on diagonal word 5g.
    function automatic int col_idx(input int g, input int p);
        return (5 * g + 4 * p) % N_WORDS;
    endfunction

    // Row group g walks along row g, starting on its diagonal word.
    function automatic int row_idx(input int g, input int p);
        return 4 * g + ((g + p) % 4);
    endfunction
endpackage

// File: rtl/salsa_qr.sv
module salsa_qr
    import salsa_pkg::*;
(
    input  quad_t qi,
    output quad_t qo
);
    word_t b1, c1, d1, a1;

    always_comb begin
        b1 = qi[1] ^ rotl(qi[0] + qi[3], 7);
        c1 = qi[2] ^ rotl(b1 + qi[0], 9);
        d1 = qi[3] ^ rotl(c1 + b1, 13);
        a1 = qi[0] ^ rotl(d1 + c1, 18);
        qo = {d1, c1, b1, a1};
    end
endmodule

// File: rtl/salsa_round.sv
module salsa_round
    import salsa_pkg::*;
(
    input  state_t st,
    input  logic   row_sel,
    output state_t nx
);
    quad_t q_in  [N_GRP];
    quad_t q_out [N_GRP];

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        for (genvar p = 0; p < 4; p++) begin : g_pos
            localparam int CI = col_idx(g, p);
            localparam int RI = row_idx(g, p);
            assign q_in[g][p] = row_sel ? st[RI] : st[CI];
        end
        salsa_qr u_qr (
            .qi(q_in[g]),
            .qo(q_out[g])
        );
    end

    always_comb begin
        nx = st;
        for (int g = 0; g < N_GRP; g++) begin
            for (int p = 0; p < 4; p++) begin
                if (row_sel) nx[row_idx(g, p)] = q_out[g][p];
                else         nx[col_idx(g, p)] = q_out[g][p];
            end
        end
    end
endmodule

// File: rtl/salsa_seq.sv
module salsa_seq
    import salsa_pkg::*;
#(
    parameter int NR_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NR_W-1:0] nr,
    output logic            load,
    output phase_e          phase
);
    localparam int CNT_W = NR_W + 1;

    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] nr_even;

    assign nr_even = {1'b0, nr} + CNT_W'(nr[0]);
    assign load    = start && (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            rem   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    rem   <= nr_even;
                    phase <= (nr_even == '0) ? PH_FEED : PH_COL;
                end
                PH_COL:  phase <= PH_ROW;
                PH_ROW: begin
                    rem   <= rem - CNT_W'(2);
                    phase <= (rem == CNT_W'(2)) ? PH_FEED : PH_COL;
                end
                PH_FEED: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/salsa_core.sv
module salsa_core
    import salsa_pkg::*;
#(
    parameter int NR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NR_W-1:0]  nr,
    input  logic [BLK_W-1:0] din,
    output logic [BLK_W-1:0] dout,
    output logic             busy,
    output logic             done
);
    phase_e phase;
    logic   load;
    state_t work, save, rnd_out, sum;

    salsa_seq #(.NR_W(NR_W)) u_seq (
        .clk(clk),
        .rst(rst),
        .start(start),
        .nr(nr),
        .load(load),
        .phase(phase)
    );

    salsa_round u_round (
        .st(work),
        .row_sel(phase == PH_ROW),
        .nx(rnd_out)
    );

    always_comb begin
        for (int i = 0; i < N_WORDS; i++) sum[i] = work[i] + save[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work <= '0;
            save <= '0;
            dout <= '0;
            done <= 1'b0;
        end else begin
            done <= (phase == PH_FEED);
            if (load) begin
                work <= din;
                save <= din;
            end else if (phase == PH_COL || phase == PH_ROW) begin
                work <= rnd_out;
            end
            if (phase == PH_FEED) dout <= sum;
        end
    end

    assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/salsa_core_chk.sv
module salsa_core_chk #(
    parameter int NR_W  = 8,
    parameter int BLK_W = 512
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [NR_W-1:0]  nr,
    input logic [BLK_W-1:0] dout,
    input logic             busy,
    input logic             done
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R6
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R9
    zero_round_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && nr == '0) |=> ##1 done);

    // R11
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(dout));
endmodule

bind salsa_core salsa_core_chk #(.NR_W(NR_W), .BLK_W(BLK_W)) u_chk (
    .clk(clk),
    .rst(rst),
    .start(start),
    .nr(nr),
    .dout(dout),
    .busy(busy),
    .done(done)
);

// File: tb/salsa_core_bench.sv
module salsa_core_bench;
    localparam int BW = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [7:0]    nr_i = '0;
    logic [BW-1:0] din_i = '0;
    logic [BW-1:0] dout;
    logic          busy, done;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    salsa_core u_salsa_core (
        .clk(clk), .rst(rst), .start(start), .nr(nr_i),
        .din(din_i), .dout(dout), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [7:0]  nr;
        logic [31:0] seed;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{nr: 8'd8,  seed: 32'h0000_1234},
        '{nr: 8'd12, seed: 32'hDEAD_BEEF},
        '{nr: 8'd20, seed: 32'h0BAD_F00D},
        '{nr: 8'd20, seed: 32'h0000_0000},
        '{nr: 8'd2,  seed: 32'h5555_AAAA}
    };

    function automatic logic [31:0] rl(input logic [31:0] v, input int s);
        return (v << s) | (v >> (32 - s));
    endfunction

    function automatic void qr(inout logic [31:0] a, inout logic [31:0] b,
                               inout logic [31:0] c, inout logic [31:0] d);
        b = b ^ rl(a + d, 7);
        c = c ^ rl(b + a, 9);
        d = d ^ rl(c + b, 13);
        a = a ^ rl(d + c, 18);
    endfunction

    function automatic logic [BW-1:0] model(input logic [BW-1:0] in, input int n);
        logic [31:0]   x [16];
        logic [BW-1:0] o;
        int            r;
        for (int i = 0; i < 16; i++) x[i] = in[32*i +: 32];
        r = n + (n % 2);
        while (r > 0) begin
            qr(x[0], x[4], x[8], x[12]);
            qr(x[5], x[9], x[13], x[1]);
            qr(x[10], x[14], x[2], x[6]);
            qr(x[15], x[3], x[7], x[11]);
            qr(x[0], x[1], x[2], x[3]);
            qr(x[5], x[6], x[7], x[4]);
            qr(x[10], x[11], x[8], x[9]);
            qr(x[15], x[12], x[13], x[14]);
            r -= 2;
        end
        for (int i = 0; i < 16; i++) o[32*i +: 32] = x[i] + in[32*i +: 32];
        return o;
    endfunction

    function automatic logic [BW-1:0] gen(input logic [31:0] seed);
        logic [BW-1:0] o;
        if (seed == 0) return '0;
        for (int i = 0; i < 16; i++)
            o[32*i +: 32] = ((seed ^ (i * 32'h85EB_CA6B)) * 32'hC2B2_AE35) + i;
        return o;
    endfunction

    task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] n, input logic [BW-1:0] d, input int ovr_at,
                       output logic [BW-1:0] res, output int lat);
        @(negedge clk);
        nr_i = n; din_i = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 600) begin
            if (lat == ovr_at) begin
                start = 1'b1; din_i = ~d; nr_i = 8'd2;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        res = dout;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [BW-1:0] res, in, keep, twice;
        int            lat;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy in reset", BW'(busy), '0);
        chk("R1 done in reset", BW'(done), '0);
        chk("R1 dout in reset", dout, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", BW'(busy), '0);

        // R2 R3 R4 R5: table of vectors against the model
        foreach (VECS[k]) begin
            in = gen(VECS[k].seed);
            run(VECS[k].nr, in, -1, res, lat);
            chk($sformatf("R2 R3 R4 R5 result nr=%0d seed=%h", VECS[k].nr, VECS[k].seed),
                res, model(in, VECS[k].nr));
            // R6 latency
            chk($sformatf("R6 latency nr=%0d", VECS[k].nr), BW'(lat), BW'(VECS[k].nr + 1));
            @(negedge clk);
            // R7 single-cycle done
            chk("R7 done drops", BW'(done), '0);
        end

        // R4 zero block gives zero output
        run(8'd20, '0, -1, res, lat);
        chk("R4 zero block", res, '0);

        // R10 odd count rounds up
        in = gen(32'h1357_9BDF);
        run(8'd7, in, -1, res, lat);
        chk("R10 odd nr result", res, model(in, 8));
        chk("R10 odd nr latency", BW'(lat), BW'(9));

        // R9 zero rounds gives doubled input
        in = gen(32'hCAFE_0001);
        for (int i = 0; i < 16; i++) twice[32*i +: 32] = in[32*i +: 32] + in[32*i +: 32];
        run(8'd0, in, -1, res, lat);
        chk("R9 nr=0 result", res, twice);
        chk("R9 nr=0 latency", BW'(lat), BW'(1));

        // R8 start while busy is ignored
        in = gen(32'h2468_ACE0);
        run(8'd20, in, 5, res, lat);
        chk("R8 result with extra start", res, model(in, 20));
        chk("R8 latency with extra start", BW'(lat), BW'(21));

        // R11 dout holds after done
        keep = dout;
        repeat (10) @(negedge clk);
        chk("R11 dout held", dout, keep);
        chk("R11 idle after run", BW'(busy), '0);

        // R1 reset during a run
        @(negedge clk);
        nr_i = 8'd20; din_i = gen(32'h0F0F_0F0F); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 busy before mid-run reset", BW'(busy), BW'(1));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after mid-run reset", BW'(busy), '0);
        chk("R1 dout after mid-run reset", dout, '0);
        repeat (25) @(negedge clk);
        chk("R1 no done from abandoned run", BW'(done), '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule